// File: doc/BRIEF.md
# Dual Threshold and Rate-of-Change Alarm

This block watches sensor output words on behalf of two independent alarm channels. On every sample strobe each channel picks one of four sources (supply voltage, angular rate, auxiliary converter, temperature), in either its filtered or its unfiltered form. It then tests either the present level or a running average of sample-to-sample change against its own threshold. The comparison direction is programmable. A channel that trips sets a sticky status bit, which stays set until the status word is read.

A single packed control word holds the per-channel source and mode fields, the filtered/unfiltered choice and the alarm pin setup. The pin can be routed to one of two general-purpose lines with either polarity, and it reflects the OR of both status bits. The block sits between the sample pipeline and the register file. It stores no configuration itself.

Top module: `dual_alarm_unit`

## Requirements
- R1: A channel source code of 3'b001 selects supply, 3'b010 rate, 3'b101 auxiliary converter and 3'b110 temperature. Code 3'b000 and every other code leave the channel inactive, so it never sets its status bit.
- R2: Threshold bit 15 set to 1 raises the alarm when the compared value is strictly greater than the threshold. Set to 0, it raises the alarm when the value is strictly less than the threshold.
- R3: In level mode, rate and temperature words and threshold bits 13:0 are compared as 14-bit two's complement. Supply and auxiliary words and threshold bits 13:0 are compared as unsigned.
- R4: Control bit 4 set to 1 selects the filtered source words, and 0 selects the unfiltered words.
- R5: Channel 1 takes its rate-of-change enable from control bit 11 and its source code from bits 10:8. Channel 2 takes them from bit 15 and bits 14:12.
- R6: In rate-of-change mode, the first strobe stores a reference sample. Every N further strobes, the channel compares (current − reference) arithmetically shifted right by floor(log2 N) against the threshold, read as 14-bit two's complement. The current sample then becomes the new reference. N is the 8-bit average count, and 0 is treated as 1. No comparison takes place inside a window.
- R7: Channel 1 status is alarmStatus bit 0 and channel 2 status is bit 1. Each bit stays set until statusRead is pulsed. A set in the same cycle as statusRead wins over the clear.
- R8: Control bit 2 enables the pin, bit 1 selects active-high (1) or active-low (0), and bit 0 picks line 1 (1) or line 0 (0). Only the chosen line has pinOe high. Its pinOut is the OR of both status bits at the chosen polarity. Unselected lines drive pinOe and pinOut low.
- R9: After reset both status bits are 0 and no rate-of-change reference is held.
- R10: A comparison made at a strobe edge shows on alarmStatus in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | New sample words are valid this cycle |
| statusRead | input | 1 | Status word read; clears sticky bits |
| supplyRaw | input | 14 | Supply word, unfiltered |
| supplyFilt | input | 14 | Supply word, filtered |
| rateRaw | input | 14 | Rate word, unfiltered |
| rateFilt | input | 14 | Rate word, filtered |
| auxRaw | input | 14 | Auxiliary converter word, unfiltered |
| auxFilt | input | 14 | Auxiliary converter word, filtered |
| tempRaw | input | 14 | Temperature word, unfiltered |
| tempFilt | input | 14 | Temperature word, filtered |
| alarmCtrl | input | 16 | Packed source, mode and pin control |
| thresh1 | input | 16 | Channel 1 direction and threshold |
| thresh2 | input | 16 | Channel 2 direction and threshold |
| avgCount | input | 8 | Delta average sample count |
| alarmStatus | output | 2 | Sticky alarm bits, channel 1 in bit 0 |
| pinOut | output | 2 | Alarm pin level per line |
| pinOe | output | 2 | Alarm pin output enable per line |

## Verification
A wrong window counter or a stale reference in rate-of-change mode shows at the ports as an alarm that comes one window early or late. It can also surface as a trip inside a window, or a missed trip on a change that the level alone would not flag. Each is visible in the cycle after the strobe that should close the window. A wrong sign extension or source decode flips the status bit on the very next strobe for values near the top of the range. A lost sticky bit shows at the next strobe that carries a benign value. Pin routing errors appear on pinOe and pinOut as soon as the control word or the status changes.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int NUM_CH  = 2;
  localparam int COUNT_W = 8;
  localparam int SHIFT_W = $clog2(COUNT_W);

  typedef struct packed {
    logic               loadRef;
    logic               compare;
    logic               roc;
    logic [SHIFT_W-1:0] shift;
  } chanStrobe_t;

  function automatic logic srcValid(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b101) || (code == 3'b110);
  endfunction

  function automatic logic srcSigned(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b110);
  endfunction

  function automatic logic [SHIFT_W-1:0] floorLog2(input logic [COUNT_W-1:0] n);
    logic [SHIFT_W-1:0] r;
    r = '0;
    for (int b = 0; b < COUNT_W; b++) begin
      if (n[b]) r = SHIFT_W'(b);
    end
    return r;
  endfunction
endpackage

// File: rtl/dual_alarm_ctrl.sv
module dual_alarm_ctrl
  import dual_alarm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleStrobe,
  input  logic [15:0]               alarmCtrl,
  input  logic [COUNT_W-1:0]        avgCount,
  output chanStrobe_t [NUM_CH-1:0]  stb
);
  logic [COUNT_W-1:0] nEff;
  logic [SHIFT_W-1:0] shiftAmt;

  assign nEff     = (avgCount == '0) ? COUNT_W'(1) : avgCount;
  assign shiftAmt = floorLog2(nEff);

  logic unusedCtrl;
  assign unusedCtrl = ^alarmCtrl[7:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [2:0]         srcCode;
    logic               rocMode;
    logic               active;
    logic               primed;
    logic [COUNT_W-1:0] cnt;
    logic               lastStep;

    assign rocMode  = alarmCtrl[11 + 4*ch];
    assign srcCode  = alarmCtrl[10 + 4*ch -: 3];
    assign active   = srcValid(srcCode);
    assign lastStep = ({1'b0, cnt} + 1'b1) >= {1'b0, nEff};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        primed <= 1'b0;
        cnt    <= '0;
      end else if (sampleStrobe) begin
        if (!active || !rocMode) begin
          primed <= 1'b0;
          cnt    <= '0;
        end else if (!primed) begin
          primed <= 1'b1;
          cnt    <= '0;
        end else if (lastStep) begin
          cnt    <= '0;
        end else begin
          cnt    <= cnt + 1'b1;
        end
      end
    end

    always_comb begin
      stb[ch].roc     = rocMode;
      stb[ch].shift   = shiftAmt;
      stb[ch].compare = sampleStrobe && active && (!rocMode || (primed && lastStep));
      stb[ch].loadRef = sampleStrobe && active && rocMode && (!primed || lastStep);
    end

    // R10: comparisons happen only on sample strobes
    assert_compare_on_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
      stb[ch].compare |-> sampleStrobe);

    // R6: in rate mode a compare always restarts the window
    assert_window_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stb[ch].compare && rocMode) |=> (cnt == '0));
  end
endmodule

// File: rtl/dual_alarm_datapath.sv
module dual_alarm_datapath
  import dual_alarm_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      statusRead,
  input  logic [DATA_W-1:0]         supplyRaw,
  input  logic [DATA_W-1:0]         supplyFilt,
  input  logic [DATA_W-1:0]         rateRaw,
  input  logic [DATA_W-1:0]         rateFilt,
  input  logic [DATA_W-1:0]         auxRaw,
  input  logic [DATA_W-1:0]         auxFilt,
  input  logic [DATA_W-1:0]         tempRaw,
  input  logic [DATA_W-1:0]         tempFilt,
  input  logic [15:0]               alarmCtrl,
  input  logic [15:0]               thresh1,
  input  logic [15:0]               thresh2,
  input  chanStrobe_t [NUM_CH-1:0]  stb,
  output logic [NUM_CH-1:0]         alarmStatus,
  output logic [1:0]                pinOut,
  output logic [1:0]                pinOe
);
  localparam int EXT_W = DATA_W + 2;

  logic              useFilt;
  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] status;

  assign useFilt = alarmCtrl[4];

  logic unusedThr;
  assign unusedThr = ^{thresh1[14:DATA_W], thresh2[14:DATA_W], alarmCtrl[7:5], alarmCtrl[3]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [2:0]               srcCode;
    logic [DATA_W-1:0]        word;
    logic                     isSigned;
    logic signed [EXT_W-1:0]  ext;
    logic signed [EXT_W-1:0]  refReg;
    logic signed [EXT_W-1:0]  delta;
    logic signed [EXT_W-1:0]  value;
    logic signed [EXT_W-1:0]  thrExt;
    logic [15:0]              thr;
    logic                     hit;

    assign srcCode  = alarmCtrl[10 + 4*ch -: 3];
    assign thr      = (ch == 0) ? thresh1 : thresh2;
    assign isSigned = srcSigned(srcCode);

    always_comb begin
      case (srcCode)
        3'b001:  word = useFilt ? supplyFilt : supplyRaw;
        3'b010:  word = useFilt ? rateFilt   : rateRaw;
        3'b101:  word = useFilt ? auxFilt    : auxRaw;
        3'b110:  word = useFilt ? tempFilt   : tempRaw;
        default: word = '0;
      endcase
    end

    assign ext    = isSigned ? {{2{word[DATA_W-1]}}, word} : {2'b00, word};
    assign thrExt = (isSigned || stb[ch].roc) ? {{2{thr[DATA_W-1]}}, thr[DATA_W-1:0]}
                                              : {2'b00, thr[DATA_W-1:0]};
    assign delta  = ext - refReg;
    assign value  = stb[ch].roc ? (delta >>> stb[ch].shift) : ext;
    assign hit    = thr[15] ? (value > thrExt) : (value < thrExt);
    assign setVec[ch] = stb[ch].compare && hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                refReg <= '0;
      else if (stb[ch].loadRef) refReg <= ext;
    end

    // R1: an inactive source code never raises a set
    assert_inactive_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
      !srcValid(srcCode) |-> !setVec[ch]);

    // R7: a status bit holds until a read clears it
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (status[ch] && !statusRead) |=> status[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (statusRead ? '0 : status) | setVec;
  end

  assign alarmStatus = status;

  logic anyOn, pinLevel;
  assign anyOn    = |status;
  assign pinLevel = alarmCtrl[1] ? anyOn : ~anyOn;
  assign pinOe    = alarmCtrl[2] ? (alarmCtrl[0] ? 2'b10 : 2'b01) : 2'b00;
  assign pinOut   = pinOe & {2{pinLevel}};

  // R7: a read with no set in that cycle empties the status word
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && setVec == '0) |=> (status == '0));

  // R8: at most one line is driven
  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pinOe));

  // R8: an undriven line carries no level
  assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == 2'b00);
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import dual_alarm_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStrobe,
  input  logic              statusRead,
  input  logic [DATA_W-1:0] supplyRaw,
  input  logic [DATA_W-1:0] supplyFilt,
  input  logic [DATA_W-1:0] rateRaw,
  input  logic [DATA_W-1:0] rateFilt,
  input  logic [DATA_W-1:0] auxRaw,
  input  logic [DATA_W-1:0] auxFilt,
  input  logic [DATA_W-1:0] tempRaw,
  input  logic [DATA_W-1:0] tempFilt,
  input  logic [15:0]       alarmCtrl,
  input  logic [15:0]       thresh1,
  input  logic [15:0]       thresh2,
  input  logic [7:0]        avgCount,
  output logic [1:0]        alarmStatus,
  output logic [1:0]        pinOut,
  output logic [1:0]        pinOe
);
  chanStrobe_t [NUM_CH-1:0] stb;

  dual_alarm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .alarmCtrl    (alarmCtrl),
    .avgCount     (avgCount),
    .stb          (stb)
  );

  dual_alarm_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .statusRead  (statusRead),
    .supplyRaw   (supplyRaw),
    .supplyFilt  (supplyFilt),
    .rateRaw     (rateRaw),
    .rateFilt    (rateFilt),
    .auxRaw      (auxRaw),
    .auxFilt     (auxFilt),
    .tempRaw     (tempRaw),
    .tempFilt    (tempFilt),
    .alarmCtrl   (alarmCtrl),
    .thresh1     (thresh1),
    .thresh2     (thresh2),
    .stb         (stb),
    .alarmStatus (alarmStatus),
    .pinOut      (pinOut),
    .pinOe       (pinOe)
  );
endmodule

// File: tb/dual_alarm_unit_bench.sv
module dual_alarm_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic        statusRead = 1'b0;
  logic [13:0] supplyRaw = '0, supplyFilt = '0, rateRaw = '0, rateFilt = '0;
  logic [13:0] auxRaw = '0, auxFilt = '0, tempRaw = '0, tempFilt = '0;
  logic [15:0] alarmCtrl = '0, thresh1 = '0, thresh2 = '0;
  logic [7:0]  avgCount = '0;
  logic [1:0]  alarmStatus, pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_alarm_unit u_dual_alarm_unit (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .statusRead(statusRead),
    .supplyRaw(supplyRaw), .supplyFilt(supplyFilt), .rateRaw(rateRaw), .rateFilt(rateFilt),
    .auxRaw(auxRaw), .auxFilt(auxFilt), .tempRaw(tempRaw), .tempFilt(tempFilt),
    .alarmCtrl(alarmCtrl), .thresh1(thresh1), .thresh2(thresh2), .avgCount(avgCount),
    .alarmStatus(alarmStatus), .pinOut(pinOut), .pinOe(pinOe)
  );

  // {ctrl, threshold (both channels), raw word, filtered word, expected status}
  localparam int NVEC = 10;
  localparam logic [61:0] VEC [NVEC] = '{
    {16'h0100, 16'h8064, 14'd200,   14'd0,   2'b01},  // R2 greater, supply
    {16'h0100, 16'h8064, 14'd100,   14'd0,   2'b00},  // R2 strict
    {16'h2200, 16'h8005, 14'h3FFD,  14'd0,   2'b00},  // R3 rate signed -3
    {16'h5100, 16'h8005, 14'h3FFD,  14'd0,   2'b11},  // R3 supply/aux unsigned
    {16'h6000, 16'h3FFE, 14'h3FFB,  14'd0,   2'b10},  // R2 less, R5 ch2 temp
    {16'h0110, 16'h8064, 14'd200,   14'd50,  2'b00},  // R4 filtered
    {16'h0110, 16'h8064, 14'd50,    14'd200, 2'b01},  // R4 filtered
    {16'h3700, 16'h8000, 14'd100,   14'd0,   2'b00},  // R1 codes 111/011
    {16'h4000, 16'h8000, 14'd100,   14'd0,   2'b00},  // R1 codes 000/100
    {16'h0500, 16'h000A, 14'd3,     14'd0,   2'b01}   // R1 aux less
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic setSrc(input logic [13:0] raw, input logic [13:0] filt);
    supplyRaw = raw; rateRaw = raw; auxRaw = raw; tempRaw = raw;
    supplyFilt = filt; rateFilt = filt; auxFilt = filt; tempFilt = filt;
  endtask

  task automatic strobe(input logic [13:0] val);
    @(negedge clk);
    setSrc(val, val);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  task automatic readClear();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset status", alarmStatus, 2'b00);
    check("R9 reset pinOe", pinOe, 2'b00);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      readClear();
      alarmCtrl = VEC[i][61:46];
      thresh1   = VEC[i][45:30];
      thresh2   = VEC[i][45:30];
      setSrc(VEC[i][29:16], VEC[i][15:2]);
      @(negedge clk);
      sampleStrobe = 1'b1;
      @(negedge clk);
      sampleStrobe = 1'b0;
      check($sformatf("R1-vector %0d (R2 R3 R4 R5 R10)", i), alarmStatus, VEC[i][1:0]);
    end

    // R7 sticky, clear, set-wins
    readClear();
    alarmCtrl = 16'h0100; thresh1 = 16'h8064; thresh2 = 16'h8064;
    strobe(14'd200);
    check("R7 set", alarmStatus, 2'b01);
    strobe(14'd50);
    check("R7 sticky", alarmStatus, 2'b01);
    readClear();
    check("R7 cleared", alarmStatus, 2'b00);
    @(negedge clk);
    setSrc(14'd200, 14'd200);
    sampleStrobe = 1'b1; statusRead = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0; statusRead = 1'b0;
    check("R7 set wins over read", alarmStatus, 2'b01);

    // R8 pin routing with status 01
    alarmCtrl = 16'h0107; #1;
    check("R8 oe line1", pinOe, 2'b10);
    check("R8 out high", pinOut, 2'b10);
    alarmCtrl = 16'h0105; #1;
    check("R8 active low asserted", pinOut, 2'b00);
    alarmCtrl = 16'h0102; #1;
    check("R8 disabled oe", pinOe, 2'b00);
    check("R8 disabled out", pinOut, 2'b00);
    alarmCtrl = 16'h0104; #1;
    check("R8 oe line0", pinOe, 2'b01);
    check("R8 line0 active low on", pinOut, 2'b00);
    readClear();
    check("R8 line0 idle high", pinOut, 2'b01);

    // R6 rate of change, N=4 -> shift 2
    alarmCtrl = 16'h0A00; thresh1 = 16'h800A; avgCount = 8'd4;
    strobe(14'd0);
    strobe(14'd20);
    strobe(14'd40);
    strobe(14'd60);
    check("R6 no compare inside window", alarmStatus, 2'b00);
    strobe(14'd80);
    check("R6 window mean 20 > 10", alarmStatus, 2'b01);
    readClear();
    strobe(14'd84);
    strobe(14'd88);
    strobe(14'd92);
    strobe(14'd96);
    check("R6 window mean 4 <= 10", alarmStatus, 2'b00);

    // R6 count 0 treated as 1
    avgCount = 8'd0;
    strobe(14'd100);
    check("R6 zero count delta 4", alarmStatus, 2'b00);
    strobe(14'd120);
    check("R6 zero count delta 20", alarmStatus, 2'b01);
    readClear();

    // R6 negative delta, less-than, count 1
    avgCount = 8'd1; thresh1 = 16'h3FF6;
    strobe(14'd100);
    check("R6 delta -20 < -10", alarmStatus, 2'b01);
    readClear();

    // R6 count 3 -> shift 1
    avgCount = 8'd3; thresh1 = 16'h800A;
    strobe(14'd106);
    strobe(14'd112);
    strobe(14'd118);
    check("R6 count3 diff 18 >>1 = 9", alarmStatus, 2'b00);
    strobe(14'd124);
    strobe(14'd130);
    strobe(14'd142);
    check("R6 count3 diff 24 >>1 = 12", alarmStatus, 2'b01);
    readClear();

    // R5 channel 2 rate of change fields
    alarmCtrl = 16'hA000; thresh2 = 16'h800A; avgCount = 8'd1;
    strobe(14'd0);
    check("R5 ch2 reference only", alarmStatus, 2'b00);
    strobe(14'd50);
    check("R5 ch2 rate trip", alarmStatus, 2'b10);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule